// File: doc/BRIEF.md
# Receive DMA Request Trigger

This block decides when the receive path should ask a bus master to start moving the frame that is currently arriving in a network receive FIFO. It counts the bytes of the current frame. When the count reaches a threshold, it raises a DMA request. In normal operation the threshold comes from a programmable two-bit watermark. In low-latency operation the threshold is fixed at 16 bytes, so that a cut-through forwarding path can begin moving a frame almost as soon as it starts. Low-latency operation is used only when external buffer memory is configured. If it is not, the block falls back to the watermark.

A small control register holds the low-latency bit and the watermark field. The register can be written only while the controller reports that it is stopped, and it can be read at any time. A hard reset clears both fields. A soft reset clears only the low-latency bit.

The request appears as a one-cycle pulse together with a level. The level stays high until the bus master acknowledges it. A frame that ends before reaching its threshold still raises its request on its end-of-frame strobe. If a new frame triggers while an older request is still waiting for its acknowledge, the new request is held back until the older one is acknowledged.

Top module: `rx_dma_trigger`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `cfg_rdata` to 000, `dma_req` to 0 and `dma_req_pulse` to 0. No request is raised for bytes that arrive before the first `frame_start`.
- R2: With the effective mode normal, the watermark field `cfg_rdata[1:0]` selects the threshold: 00 gives 16 bytes, 01 gives 64, 10 gives 112 and 11 gives 256. `dma_req_pulse` is high for exactly the one cycle after the clock edge that captures the threshold-th byte of the frame. `frame_start` accompanies the first byte.
- R3: When the low-latency bit `cfg_rdata[2]` is 1 and `buf_mem_nz` is 1, the request fires on the 16th byte, whatever the watermark holds.
- R4: When the low-latency bit is 1 but `buf_mem_nz` is 0, the block uses the watermark threshold of R2.
- R5: A write on `cfg_wr_en` stores `cfg_wdata` (bit 2 is the low-latency bit, bits 1:0 are the watermark) only while `ctrl_stopped` is 1. At other times the write leaves `cfg_rdata` unchanged. `cfg_rdata` always shows the stored value.
- R6: `soft_rst` clears the low-latency bit and keeps the watermark. Changing `ctrl_stopped` does not alter either field.
- R7: A frame raises at most one request, even when it runs beyond the 2047-byte saturation limit of the byte counter.
- R8: A frame whose `frame_end` strobe arrives before its threshold is reached raises its request on the edge that captures `frame_end`.
- R9: `dma_req` stays high until a cycle with `dma_ack` high. It is low in the following cycle. An acknowledge while `dma_req` is low has no effect.
- R10: A request triggered while `dma_req` is still high is held back. It is raised, with its pulse, in the second cycle after the acknowledging edge.
- R11: `dma_req_pulse` is high exactly in the cycles in which `dma_req` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset; clears the low-latency bit only |
| ctrl_stopped | input | 1 | High while the controller is stopped; enables register writes |
| buf_mem_nz | input | 1 | High when the external buffer size is configured non-zero |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Write data: bit 2 low-latency, bits 1:0 watermark |
| cfg_rdata | output | 3 | Stored control register value |
| byte_vld | input | 1 | One received byte entered the FIFO this cycle |
| frame_start | input | 1 | Start of a new frame, given with its first byte |
| frame_end | input | 1 | Last byte of the current frame |
| dma_ack | input | 1 | One-cycle acknowledge of the pending request |
| dma_req | output | 1 | Request level, held until acknowledged |
| dma_req_pulse | output | 1 | One-cycle pulse when a request is raised |

## Verification
A wrong byte count, a wrong threshold selection or a wrong per-frame done flag shows up at the ports in the very cycle after the edge that should have raised the request. The pulse then appears early, late, twice or not at all. A wrong held-back request flag shows only after the next acknowledge, when the second request fails to appear two cycles later or appears without a trigger. Control register faults show on `cfg_rdata` one cycle after the offending write or reset.

// File: rtl/rxdt_pkg.sv
// Package: shared constants and the watermark-to-threshold function
// for the receive DMA request trigger.
package rxdt_pkg;

    // Width of the per-frame byte counter (saturates at all ones)
    localparam int unsigned CNT_W      = 11;
    // Width of the watermark select field
    localparam int unsigned WM_W       = 2;
    // Width of the control register image (mode bit plus watermark)
    localparam int unsigned CFG_W      = WM_W + 1;
    // Bit position of the low-latency mode bit in the register image
    localparam int unsigned LL_BIT     = WM_W;

    // Map a watermark code onto a byte threshold: codes below the top one
    // step up linearly from a base, the top code selects a separate value.
    function automatic logic [CNT_W-1:0] wm_to_thresh(
        input logic [WM_W-1:0] wm,
        input int unsigned     base,
        input int unsigned     step,
        input int unsigned     top
    );
        int unsigned v;
        if (wm == {WM_W{1'b1}}) begin
            v = top;
        end else begin
            v = base + step * int'(wm);
        end
        return v[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/rxdt_cfg_reg.sv
// Control register holding the low-latency mode bit and the watermark.
// Assumes: rst_n is a synchronous active-low hard reset; soft_rst is a
// synchronous active-high soft reset that clears only the mode bit and
// takes priority over a write in the same cycle; writes land only while
// the controller reports stopped.
module rxdt_cfg_reg
    import rxdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ctrl_stopped,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic             ll_bit,
    output logic [WM_W-1:0]  wm
);

    logic             ll_q;
    logic [WM_W-1:0]  wm_q;
    logic             wr_ok;

    // Purpose: a write is accepted only while the controller is stopped
    always_comb begin
        wr_ok = wr_en && ctrl_stopped;
    end

    // Purpose: hold the mode bit; cleared by both resets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ll_q <= 1'b0;
        end else if (soft_rst) begin
            ll_q <= 1'b0;
        end else if (wr_ok) begin
            ll_q <= wdata[LL_BIT];
        end
    end

    // Purpose: hold the watermark; cleared only by hard reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm_q <= '0;
        end else if (wr_ok && !soft_rst) begin
            wm_q <= wdata[WM_W-1:0];
        end
    end

    assign ll_bit = ll_q;
    assign wm     = wm_q;

endmodule

// File: rtl/rxdt_frame_count.sv
// Per-frame byte counter and trigger detector.
// Assumes: frame_start comes with the first byte of a frame (or alone for
// an empty frame); frame_end marks the last byte. The counter saturates
// at its all-ones value. A done flag limits each frame to one trigger
// and starts set, so that no trigger occurs before the first frame_start.
module rxdt_frame_count
    import rxdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic [CNT_W-1:0] thresh,
    output logic             trig
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_base, cnt_nxt;
    logic             done_q, done_base, done_nxt;

    // Purpose: compute next count, and whether this cycle triggers
    always_comb begin
        cnt_base  = frame_start ? '0   : cnt_q;
        done_base = frame_start ? 1'b0 : done_q;
        if (byte_vld && (cnt_base != CNT_MAX)) begin
            cnt_nxt = cnt_base + 1'b1;
        end else begin
            cnt_nxt = cnt_base;
        end
        trig     = !done_base && (frame_end || (cnt_nxt >= thresh));
        done_nxt = done_base || trig;
    end

    // Purpose: register count and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_nxt;
            done_q <= done_nxt;
        end
    end

endmodule

// File: rtl/rxdt_req_ctrl.sv
// Request output stage: raises a held level plus a one-cycle pulse. A
// trigger that arrives while the level is still waiting for its
// acknowledge is remembered in a single flag and launched once the
// level has dropped. Further triggers while that flag is set merge into it.
module rxdt_req_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic ack,
    output logic req,
    output logic req_pulse
);

    logic req_q, due_q, pulse_q;
    logic want, launch;

    // Purpose: launch when something is wanted and the level is free
    always_comb begin
        want   = trig || due_q;
        launch = want && !req_q;
    end

    // Purpose: hold level, deferred flag and pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            due_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            req_q   <= launch || (req_q && !ack);
            due_q   <= want && !launch;
            pulse_q <= launch;
        end
    end

    assign req       = req_q;
    assign req_pulse = pulse_q;

endmodule

// File: rtl/rx_dma_trigger.sv
// Top level of the receive DMA request trigger. It selects the effective
// threshold (fixed low-latency value, or the watermark table), counts the
// bytes of each frame and drives the request handshake.
// Assumes: single clock domain, all inputs synchronous to clk.
module rx_dma_trigger
    import rxdt_pkg::*;
#(
    parameter int unsigned LL_THRESH = 16,
    parameter int unsigned WM_BASE   = 16,
    parameter int unsigned WM_STEP   = 48,
    parameter int unsigned WM_TOP    = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ctrl_stopped,
    input  logic             buf_mem_nz,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             byte_vld,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             dma_ack,
    output logic             dma_req,
    output logic             dma_req_pulse
);

    localparam logic [CNT_W-1:0] LL_THR_V = LL_THRESH[CNT_W-1:0];

    logic             ll_bit;
    logic [WM_W-1:0]  wm;
    logic             ll_eff;
    logic [CNT_W-1:0] thresh;
    logic             trig;

    rxdt_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .ctrl_stopped (ctrl_stopped),
        .wr_en        (cfg_wr_en),
        .wdata        (cfg_wdata),
        .ll_bit       (ll_bit),
        .wm           (wm)
    );

    // Purpose: low-latency applies only with buffer memory present
    always_comb begin
        ll_eff = ll_bit && buf_mem_nz;
        thresh = ll_eff ? LL_THR_V : wm_to_thresh(wm, WM_BASE, WM_STEP, WM_TOP);
    end

    rxdt_frame_count u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_vld    (byte_vld),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .thresh      (thresh),
        .trig        (trig)
    );

    rxdt_req_ctrl u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .ack       (dma_ack),
        .req       (dma_req),
        .req_pulse (dma_req_pulse)
    );

    assign cfg_rdata = {ll_bit, wm};

endmodule

// File: rtl/rx_dma_trigger_chk.sv
// Checker for rx_dma_trigger: port-level handshake and register rules.
module rx_dma_trigger_chk
    import rxdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             ctrl_stopped,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             dma_ack,
    input logic             dma_req,
    input logic             dma_req_pulse
);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req);

    // R9
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |=> !dma_req);

    // R11
    pulse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_pulse |-> $rose(dma_req));

    // R11
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> dma_req_pulse);

    // R5
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_stopped && !soft_rst) |=> $stable(cfg_rdata));

    // R6
    soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!cfg_rdata[LL_BIT]
                      && (cfg_rdata[WM_W-1:0] == $past(cfg_rdata[WM_W-1:0]))));

endmodule

bind rx_dma_trigger rx_dma_trigger_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .ctrl_stopped  (ctrl_stopped),
    .cfg_rdata     (cfg_rdata),
    .dma_ack       (dma_ack),
    .dma_req       (dma_req),
    .dma_req_pulse (dma_req_pulse)
);

// File: tb/rx_dma_trigger_tb.sv
`timescale 1ns/1ps
// Bench: sweeps mode bit, buffer flag, watermark and frame length; checks
// register rules, deferral and saturation against arithmetic expectations.
module rx_dma_trigger_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       ctrl_stopped = 1'b1;
    logic       buf_mem_nz = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [2:0] cfg_wdata = 3'b000;
    logic [2:0] cfg_rdata;
    logic       byte_vld = 1'b0;
    logic       frame_start = 1'b0;
    logic       frame_end = 1'b0;
    logic       dma_ack = 1'b0;
    logic       dma_req;
    logic       dma_req_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rx_dma_trigger u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .ctrl_stopped  (ctrl_stopped),
        .buf_mem_nz    (buf_mem_nz),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .byte_vld      (byte_vld),
        .frame_start   (frame_start),
        .frame_end     (frame_end),
        .dma_ack       (dma_ack),
        .dma_req       (dma_req),
        .dma_req_pulse (dma_req_pulse)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [2:0] v);
        ctrl_stopped = 1'b1;
        cfg_wr_en    = 1'b1;
        cfg_wdata    = v;
        tick();
        cfg_wr_en    = 1'b0;
        chk(cfg_rdata, v, "R5 write while stopped");
        ctrl_stopped = 1'b0;
    endtask

    // Drive one frame; expect the pulse after the fire-th byte
    task automatic run_frame(input int len, input int fire, input string tag);
        for (int i = 1; i <= len; i++) begin
            byte_vld    = 1'b1;
            frame_start = (i == 1);
            frame_end   = (i == len);
            tick();
            chk(dma_req_pulse, (i == fire) ? 1 : 0, tag);
            chk(dma_req, (i >= fire) ? 1 : 0, tag);
        end
        byte_vld  = 1'b0;
        frame_end = 1'b0;
        tick();
        chk(dma_req_pulse, 0, tag);
    endtask

    task automatic do_ack();
        dma_ack = 1'b1;
        tick();
        dma_ack = 1'b0;
        chk(dma_req, 0, "R9 level drops after ack");
    endtask

    initial begin
        int lens[13] = '{1, 15, 16, 17, 63, 64, 65, 111, 112, 113, 255, 256, 257};
        repeat (3) tick();
        chk(cfg_rdata, 0, "R1 reset cfg");
        chk(dma_req, 0, "R1 reset req");
        chk(dma_req_pulse, 0, "R1 reset pulse");
        rst_n = 1'b1;
        ctrl_stopped = 1'b0;
        // R1: bytes before any frame_start raise nothing
        byte_vld = 1'b1;
        repeat (40) tick();
        byte_vld = 1'b0;
        chk(dma_req, 0, "R1 no request before first frame");

        // R5: write while running is ignored
        cfg_wr_en = 1'b1;
        cfg_wdata = 3'b111;
        tick();
        cfg_wr_en = 1'b0;
        chk(cfg_rdata, 0, "R5 write ignored while running");

        // R6: soft reset clears the mode bit, keeps the watermark
        write_cfg(3'b110);
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        chk(cfg_rdata, 3'b010, "R6 soft reset clears mode only");
        write_cfg(3'b101);
        ctrl_stopped = 1'b1;
        tick();
        ctrl_stopped = 1'b0;
        tick();
        chk(cfg_rdata, 3'b101, "R6 stop toggle keeps register");

        // R9: ack while idle has no effect
        dma_ack = 1'b1;
        tick();
        dma_ack = 1'b0;
        chk(dma_req, 0, "R9 idle ack ignored");

        // Sweep mode, buffer flag, watermark and frame length
        for (int ll = 0; ll < 2; ll++) begin
            for (int nz = 0; nz < 2; nz++) begin
                for (int wm = 0; wm < 4; wm++) begin
                    int thr;
                    buf_mem_nz = nz[0];
                    write_cfg({ll[0], wm[1:0]});
                    if (ll == 1 && nz == 1) thr = 16;
                    else thr = (wm == 3) ? 256 : 16 + 48 * wm;
                    foreach (lens[k]) begin
                        int fire;
                        string tag;
                        fire = (lens[k] < thr) ? lens[k] : thr;
                        if (lens[k] < thr) tag = "R8 short frame";
                        else if (ll == 1 && nz == 1) tag = "R3 low-latency";
                        else if (ll == 1) tag = "R4 no buffer memory";
                        else tag = "R2 watermark";
                        run_frame(lens[k], fire, tag);
                        do_ack();
                    end
                end
            end
        end

        // R7: frame longer than the counter limit fires once
        buf_mem_nz = 1'b0;
        write_cfg(3'b000);
        run_frame(2100, 16, "R7 single request on long frame");
        do_ack();

        // R10: second frame's request waits for the first ack
        run_frame(16, 16, "R10 first frame");
        run_frame(20, 0, "R10 second frame held");
        tick();
        chk(dma_req, 1, "R10 first level still held");
        dma_ack = 1'b1;
        tick();
        dma_ack = 1'b0;
        chk(dma_req, 0, "R10 drop after ack");
        chk(dma_req_pulse, 0, "R10 no pulse at drop");
        tick();
        chk(dma_req, 1, "R10 held request raised");
        chk(dma_req_pulse, 1, "R11 pulse with rise");
        tick();
        chk(dma_req_pulse, 0, "R11 pulse one cycle");
        chk(dma_req, 1, "R9 level held");
        do_ack();
        tick();
        chk(dma_req, 0, "R10 nothing further pending");

        // R1: hard reset clears register after use
        write_cfg(3'b111);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk(cfg_rdata, 0, "R1 hard reset clears register");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule